// File: doc/BRIEF.md
# MESI directory sharer tracker

This block is the coherence directory of one slice of a shared last-level cache. For each line it keeps a MESI state, a precise bit vector of the tiles that hold the line as data, and a second vector of the tiles that hold it in an instruction cache. It takes one coherence request at a time from a requesting tile and decides which other tiles must be probed. The request types are data load, exclusive store, dirty writeback, instruction fetch and uncached access. The block then sends one snoop message that carries a data-holder mask and an instruction-holder mask. It waits until every targeted tile has replied, writes the new directory entry, and sends the final grant to the requester.

Private caches may drop clean lines without telling the directory, so sharer bits can be stale. A stale tile is still probed and still replies. Dirty writebacks are applied without any acknowledgment. Uncached accesses go past the directory and are answered without touching it. Requests are handled strictly in the order they were accepted, because the block accepts nothing new until the current transaction has been granted.

Top module: `mesi_dir_tracker`

## Requirements
- R1: After reset, `req_ready` is 1, `snoop_valid` and `grant_valid` are 0, and every line is Invalid, so a first data load to any line is granted exclusive with no snoop.
- R2: A data load (op 0) to an Invalid line is granted exclusive (grant code 1), and the requester becomes the only data holder.
- R3: A data load to a Shared line is granted shared (code 0) with no data snoop, and the requester's bit is ORed into the data vector.
- R4: A data load to an Exclusive or Modified line held by another tile snoops that owner through the data mask, and is then granted shared (code 0) with both tiles as data holders. A reload by the owner itself is granted again as exclusive (code 1) or modified (code 2), with no snoop.
- R5: A store (op 1) snoops all other data holders and all instruction-cache holders. It is granted modified (code 2), and the requester becomes the only data holder.
- R6: A data load to a line that has instruction-cache holders first snoops all of them through the instruction mask, then clears that vector.
- R7: An instruction fetch (op 3) is granted shared (code 0) and adds the requester to the instruction vector. If the line is Exclusive or Modified at another tile, that owner is snooped through the data mask and the line becomes Shared.
- R8: A writeback (op 2) from the Modified owner makes the line Invalid and produces no grant. A writeback from any other tile produces no grant and leaves the entry unchanged.
- R9: An uncached access (op 4) is granted with code 3. It sends no snoop and leaves the directory entry unchanged.
- R10: The grant is issued only after one reply has arrived from every tile set in the snoop masks, stale holders included. The outstanding-reply count always equals the population count of the tiles still awaited.
- R11: Only one request is handled at a time. `req_ready` falls in the cycle after acceptance and stays low until the grant cycle has passed, so requests are serviced in the order they were accepted.
- R12: A snoop is a one-cycle pulse that never coincides with a grant, and it always targets at least one tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 3 | 0 load, 1 store, 2 writeback, 3 instruction fetch, 4 uncached |
| req_tile | input | TW | Requesting tile |
| req_line | input | LW | Directory line index |
| snoop_valid | output | 1 | Snoop message valid |
| snoop_dmask | output | NTILES | Data holders to probe |
| snoop_imask | output | NTILES | Instruction-cache holders to invalidate |
| ack_valid | input | 1 | Reply from a probed tile |
| ack_tile | input | TW | Tile that sent the reply |
| grant_valid | output | 1 | Final response valid |
| grant_tile | output | TW | Tile receiving the response |
| grant_line | output | LW | Line of the response |
| grant_state | output | 2 | 0 shared, 1 exclusive, 2 modified, 3 uncached |

## Verification
The bound checker examines the handshake and reply bookkeeping on every cycle. It checks that the reply count matches the awaited set, that no grant leaves while replies are missing, that a snoop is a single pulse separate from any grant and never empty, and that acceptance always closes the request port. State transitions, sharer-vector contents and the grant codes depend on the history of each line. Only the bench scenarios can show them: long sequences on several lines, stale writebacks, uncached accesses and a line with all 64 tiles sharing, each checked against a reference model of the requirements.

// File: rtl/mesi_dir_pkg.sv
package mesi_dir_pkg;

    typedef enum logic [2:0] {
        OP_LOAD      = 3'd0,
        OP_STORE     = 3'd1,
        OP_WRITEBACK = 3'd2,
        OP_IFETCH    = 3'd3,
        OP_UNCACHED  = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_e;

    typedef enum logic [1:0] {
        GR_SHARED   = 2'd0,
        GR_EXCL     = 2'd1,
        GR_MOD      = 2'd2,
        GR_UNCACHED = 2'd3
    } grant_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SNOOP = 2'd1,
        PH_WAIT  = 2'd2,
        PH_GRANT = 2'd3
    } phase_e;

    // Outcome of one request, fixed at acceptance and applied at grant.
    typedef struct packed {
        mesi_e  st;
        grant_e gr;
        logic   update;
        logic   respond;
    } verdict_t;

    function automatic logic is_owned(mesi_e s);
        return (s == ST_E) || (s == ST_M);
    endfunction

endpackage

// File: rtl/mesi_dir_store.sv
module mesi_dir_store
    import mesi_dir_pkg::*;
#(
    parameter int unsigned NTILES = 64,
    parameter int unsigned NLINES = 16,
    localparam int unsigned LW = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LW-1:0]     rd_line,
    output mesi_e             rd_state,
    output logic [NTILES-1:0] rd_dvec,
    output logic [NTILES-1:0] rd_ivec,
    input  logic              wr_en,
    input  logic [LW-1:0]     wr_line,
    input  mesi_e             wr_state,
    input  logic [NTILES-1:0] wr_dvec,
    input  logic [NTILES-1:0] wr_ivec
);

    mesi_e             st_q   [NLINES];
    logic [NTILES-1:0] dvec_q [NLINES];
    logic [NTILES-1:0] ivec_q [NLINES];

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]   <= ST_I;
                dvec_q[g] <= '0;
                ivec_q[g] <= '0;
            end else if (wr_en && (wr_line == LW'(g))) begin
                st_q[g]   <= wr_state;
                dvec_q[g] <= wr_dvec;
                ivec_q[g] <= wr_ivec;
            end
        end
    end

    assign rd_state = st_q[rd_line];
    assign rd_dvec  = dvec_q[rd_line];
    assign rd_ivec  = ivec_q[rd_line];

endmodule

// File: rtl/mesi_dir_policy.sv
module mesi_dir_policy
    import mesi_dir_pkg::*;
#(
    parameter int unsigned NTILES = 64,
    localparam int unsigned TW = $clog2(NTILES)
) (
    input  op_e               op,
    input  logic [TW-1:0]     tile,
    input  mesi_e             cur_state,
    input  logic [NTILES-1:0] cur_dvec,
    input  logic [NTILES-1:0] cur_ivec,
    output logic [NTILES-1:0] tgt_dmask,
    output logic [NTILES-1:0] tgt_imask,
    output logic [NTILES-1:0] nxt_dvec,
    output logic [NTILES-1:0] nxt_ivec,
    output verdict_t          verdict
);

    logic [NTILES-1:0] self_bit;
    logic [NTILES-1:0] others;

    assign self_bit = NTILES'(1) << tile;
    assign others   = cur_dvec & ~self_bit;

    always_comb begin
        tgt_dmask = '0;
        tgt_imask = '0;
        nxt_dvec  = cur_dvec;
        nxt_ivec  = cur_ivec;
        verdict   = '{st: cur_state, gr: GR_SHARED, update: 1'b0, respond: 1'b1};
        unique case (op)
            OP_LOAD: begin
                verdict.update = 1'b1;
                tgt_imask      = cur_ivec;
                nxt_ivec       = '0;
                if (is_owned(cur_state) && (others != '0)) begin
                    tgt_dmask  = others;
                    nxt_dvec   = cur_dvec | self_bit;
                    verdict.st = ST_S;
                    verdict.gr = GR_SHARED;
                end else if (is_owned(cur_state)) begin
                    verdict.gr = (cur_state == ST_M) ? GR_MOD : GR_EXCL;
                end else if (cur_state == ST_S) begin
                    nxt_dvec   = cur_dvec | self_bit;
                    verdict.gr = GR_SHARED;
                end else begin
                    nxt_dvec   = self_bit;
                    verdict.st = ST_E;
                    verdict.gr = GR_EXCL;
                end
            end
            OP_STORE: begin
                verdict.update = 1'b1;
                tgt_dmask      = others;
                tgt_imask      = cur_ivec;
                nxt_dvec       = self_bit;
                nxt_ivec       = '0;
                verdict.st     = ST_M;
                verdict.gr     = GR_MOD;
            end
            OP_WRITEBACK: begin
                verdict.respond = 1'b0;
                if ((cur_state == ST_M) && cur_dvec[tile]) begin
                    verdict.update = 1'b1;
                    verdict.st     = ST_I;
                    nxt_dvec       = '0;
                end
            end
            OP_IFETCH: begin
                verdict.update = 1'b1;
                nxt_ivec       = cur_ivec | self_bit;
                verdict.gr     = GR_SHARED;
                if (is_owned(cur_state) && (others != '0)) begin
                    tgt_dmask  = others;
                    verdict.st = ST_S;
                end
            end
            default: begin
                verdict.gr = GR_UNCACHED;
            end
        endcase
    end

endmodule

// File: rtl/mesi_dir_ack_collector.sv
module mesi_dir_ack_collector #(
    parameter int unsigned NTILES = 64,
    localparam int unsigned TW = $clog2(NTILES),
    localparam int unsigned CW = $clog2(NTILES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NTILES-1:0] load_mask,
    input  logic              ack_valid,
    input  logic [TW-1:0]     ack_tile,
    output logic [NTILES-1:0] pending,
    output logic [CW-1:0]     count,
    output logic              done
);

    logic [CW-1:0] load_pop;

    always_comb begin
        load_pop = '0;
        for (int i = 0; i < NTILES; i++) begin
            load_pop = load_pop + CW'(load_mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            count   <= '0;
        end else if (load) begin
            pending <= load_mask;
            count   <= load_pop;
        end else if (ack_valid && pending[ack_tile]) begin
            pending[ack_tile] <= 1'b0;
            count             <= count - CW'(1);
        end
    end

    assign done = (count == '0);

endmodule

// File: rtl/mesi_dir_tracker.sv
module mesi_dir_tracker
    import mesi_dir_pkg::*;
#(
    parameter int unsigned NTILES = 64,
    parameter int unsigned NLINES = 16,
    localparam int unsigned TW = $clog2(NTILES),
    localparam int unsigned LW = $clog2(NLINES),
    localparam int unsigned CW = $clog2(NTILES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [TW-1:0]     req_tile,
    input  logic [LW-1:0]     req_line,
    output logic              snoop_valid,
    output logic [NTILES-1:0] snoop_dmask,
    output logic [NTILES-1:0] snoop_imask,
    input  logic              ack_valid,
    input  logic [TW-1:0]     ack_tile,
    output logic              grant_valid,
    output logic [TW-1:0]     grant_tile,
    output logic [LW-1:0]     grant_line,
    output logic [1:0]        grant_state
);

    phase_e            phase;
    logic              accept;

    mesi_e             rd_state;
    logic [NTILES-1:0] rd_dvec, rd_ivec;

    logic [NTILES-1:0] pol_dmask, pol_imask, pol_dvec, pol_ivec;
    verdict_t          pol_verdict;

    verdict_t          lat_verdict;
    logic [TW-1:0]     lat_tile;
    logic [LW-1:0]     lat_line;
    logic [NTILES-1:0] lat_dmask, lat_imask, lat_dvec, lat_ivec;

    logic [NTILES-1:0] coll_pending;
    logic [CW-1:0]     coll_count;
    logic              coll_done;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    mesi_dir_store #(.NTILES(NTILES), .NLINES(NLINES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_line  (req_line),
        .rd_state (rd_state),
        .rd_dvec  (rd_dvec),
        .rd_ivec  (rd_ivec),
        .wr_en    ((phase == PH_GRANT) && lat_verdict.update),
        .wr_line  (lat_line),
        .wr_state (lat_verdict.st),
        .wr_dvec  (lat_dvec),
        .wr_ivec  (lat_ivec)
    );

    mesi_dir_policy #(.NTILES(NTILES)) u_policy (
        .op        (op_e'(req_op)),
        .tile      (req_tile),
        .cur_state (rd_state),
        .cur_dvec  (rd_dvec),
        .cur_ivec  (rd_ivec),
        .tgt_dmask (pol_dmask),
        .tgt_imask (pol_imask),
        .nxt_dvec  (pol_dvec),
        .nxt_ivec  (pol_ivec),
        .verdict   (pol_verdict)
    );

    mesi_dir_ack_collector #(.NTILES(NTILES)) u_collect (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_mask (pol_dmask | pol_imask),
        .ack_valid (ack_valid),
        .ack_tile  (ack_tile),
        .pending   (coll_pending),
        .count     (coll_count),
        .done      (coll_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            lat_verdict <= '{st: ST_I, gr: GR_SHARED, update: 1'b0, respond: 1'b0};
            lat_tile    <= '0;
            lat_line    <= '0;
            lat_dmask   <= '0;
            lat_imask   <= '0;
            lat_dvec    <= '0;
            lat_ivec    <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        lat_verdict <= pol_verdict;
                        lat_tile    <= req_tile;
                        lat_line    <= req_line;
                        lat_dmask   <= pol_dmask;
                        lat_imask   <= pol_imask;
                        lat_dvec    <= pol_dvec;
                        lat_ivec    <= pol_ivec;
                        phase       <= ((pol_dmask | pol_imask) != '0) ? PH_SNOOP : PH_GRANT;
                    end
                end
                PH_SNOOP: phase <= PH_WAIT;
                PH_WAIT:  if (coll_done) phase <= PH_GRANT;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assign snoop_valid = (phase == PH_SNOOP);
    assign snoop_dmask = lat_dmask;
    assign snoop_imask = lat_imask;
    assign grant_valid = (phase == PH_GRANT) && lat_verdict.respond;
    assign grant_tile  = lat_tile;
    assign grant_line  = lat_line;
    assign grant_state = lat_verdict.gr;

endmodule

// File: rtl/mesi_dir_tracker_chk.sv
module mesi_dir_tracker_chk #(
    parameter int unsigned NTILES = 64,
    localparam int unsigned CW = $clog2(NTILES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              snoop_valid,
    input logic [NTILES-1:0] snoop_dmask,
    input logic [NTILES-1:0] snoop_imask,
    input logic              grant_valid,
    input logic [NTILES-1:0] coll_pending,
    input logic [CW-1:0]     coll_count
);

    // R10
    count_match_chk: assert property (@(posedge clk) disable iff (rst)
        int'(coll_count) == $countones(coll_pending));

    // R10
    grant_after_replies_chk: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (coll_pending == '0));

    // R11
    accept_closes_port_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R11
    snoop_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |-> !req_ready);

    // R12
    snoop_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |=> (!snoop_valid && !grant_valid));

    // R12
    snoop_grant_apart_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snoop_valid, grant_valid}));

    // R12
    snoop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        snoop_valid |-> ((snoop_dmask | snoop_imask) != '0));

endmodule

bind mesi_dir_tracker mesi_dir_tracker_chk #(.NTILES(NTILES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .snoop_valid  (snoop_valid),
    .snoop_dmask  (snoop_dmask),
    .snoop_imask  (snoop_imask),
    .grant_valid  (grant_valid),
    .coll_pending (coll_pending),
    .coll_count   (coll_count)
);

// File: tb/mesi_dir_tracker_test.sv
module mesi_dir_tracker_test;

    localparam int NT = 64;
    localparam int NL = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [5:0]    req_tile = '0;
    logic [3:0]    req_line = '0;
    logic          snoop_valid;
    logic [NT-1:0] snoop_dmask, snoop_imask;
    logic          ack_valid = 1'b0;
    logic [5:0]    ack_tile = '0;
    logic          grant_valid;
    logic [5:0]    grant_tile;
    logic [3:0]    grant_line;
    logic [1:0]    grant_state;

    always #2.5 clk = ~clk;

    mesi_dir_tracker uut (.*);

    int checks = 0;
    int errors = 0;

    typedef struct { logic [NT-1:0] dm; logic [NT-1:0] im; string tag; } snoop_item_t;
    typedef struct { logic [5:0] tile; logic [3:0] line; logic [1:0] gs; string tag; } grant_item_t;
    snoop_item_t snoop_q[$];
    grant_item_t grant_q[$];
    int          ack_q[$];

    // Reference model: 0 I, 1 S, 2 E, 3 M
    int            m_st [NL];
    logic [NT-1:0] m_dv [NL];
    logic [NT-1:0] m_iv [NL];

    task automatic check(input logic ok, input string tag, input logic [NT-1:0] act,
                         input logic [NT-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input int op, input int tile, input int line, input string tag);
        logic [NT-1:0] rb, oth, dm, im;
        logic [1:0] gs;
        bit respond;
        rb = NT'(1) << tile;
        oth = m_dv[line] & ~rb;
        dm = '0; im = '0; gs = 2'd0; respond = 1'b1;
        case (op)
            0: begin
                im = m_iv[line]; m_iv[line] = '0;
                if (m_st[line] >= 2) begin
                    if (oth != '0) begin dm = oth; m_dv[line] |= rb; m_st[line] = 1; gs = 0; end
                    else gs = (m_st[line] == 3) ? 2'd2 : 2'd1;
                end else if (m_st[line] == 1) begin m_dv[line] |= rb; gs = 0; end
                else begin m_dv[line] = rb; m_st[line] = 2; gs = 1; end
            end
            1: begin dm = oth; im = m_iv[line]; m_dv[line] = rb; m_iv[line] = '0; m_st[line] = 3; gs = 2; end
            2: begin
                respond = 1'b0;
                if (m_st[line] == 3 && m_dv[line][tile]) begin m_st[line] = 0; m_dv[line] = '0; end
            end
            3: begin
                m_iv[line] |= rb; gs = 0;
                if (m_st[line] >= 2 && oth != '0) begin dm = oth; m_st[line] = 1; end
            end
            default: gs = 3;
        endcase
        if ((dm | im) != '0) snoop_q.push_back('{dm: dm, im: im, tag: tag});
        if (respond) grant_q.push_back('{tile: 6'(tile), line: 4'(line), gs: gs, tag: tag});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = 3'(op); req_tile = 6'(tile); req_line = 4'(line); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor and reply responder
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && snoop_valid) begin
                if (snoop_q.size() == 0) begin
                    check(1'b0, "R12 unexpected snoop", snoop_dmask, '0);
                end else begin
                    snoop_item_t e;
                    e = snoop_q.pop_front();
                    check(snoop_dmask == e.dm, {e.tag, " data mask"}, snoop_dmask, e.dm);
                    check(snoop_imask == e.im, {e.tag, " icache mask"}, snoop_imask, e.im);
                    check(!req_ready, "R11 port closed during snoop", NT'(req_ready), '0);
                    for (int i = NT - 1; i >= 0; i--)
                        if (e.dm[i] || e.im[i]) ack_q.push_back(i);
                end
            end
            if (!rst && grant_valid) begin
                if (grant_q.size() == 0) begin
                    check(1'b0, "R8 unexpected grant", NT'(grant_tile), '0);
                end else begin
                    grant_item_t g;
                    g = grant_q.pop_front();
                    check(grant_tile == g.tile, {g.tag, " grant tile"}, NT'(grant_tile), NT'(g.tile));
                    check(grant_line == g.line, {g.tag, " grant line"}, NT'(grant_line), NT'(g.line));
                    check(grant_state == g.gs, {g.tag, " grant code"}, NT'(grant_state), NT'(g.gs));
                    check(ack_q.size() == 0, "R10 grant before all replies", NT'(ack_q.size()), '0);
                end
            end
            if (ack_q.size() > 0) begin
                ack_valid = 1'b1;
                ack_tile = 6'(ack_q.pop_front());
            end else begin
                ack_valid = 1'b0;
            end
        end
    end

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int l = 0; l < NL; l++) begin m_st[l] = 0; m_dv[l] = '0; m_iv[l] = '0; end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", NT'(req_ready), NT'(1));
        check(snoop_valid == 1'b0, "R1 no snoop after reset", NT'(snoop_valid), '0);
        check(grant_valid == 1'b0, "R1 no grant after reset", NT'(grant_valid), '0);
        rst = 1'b0;

        // line 1: load/store/writeback sequences
        issue(0, 3, 1, "R1 R2 first load exclusive");
        issue(0, 5, 1, "R4 load recalls owner");
        issue(0, 9, 1, "R3 load on shared");
        issue(1, 5, 1, "R5 store invalidates sharers");
        issue(0, 5, 1, "R4 owner reload modified");
        issue(2, 9, 1, "R8 stale writeback ignored");
        issue(1, 12, 1, "R8 R5 owner still tracked after stale writeback");
        issue(2, 12, 1, "R8 owner writeback");
        issue(0, 20, 1, "R8 R2 line invalid after writeback");
        issue(4, 3, 1, "R9 uncached grant");
        issue(0, 21, 1, "R9 R4 entry untouched by uncached");

        // line 2: instruction holders
        issue(3, 1, 2, "R7 ifetch shared");
        issue(3, 2, 2, "R7 second ifetch");
        issue(0, 4, 2, "R6 load invalidates icache holders");
        issue(0, 4, 2, "R6 icache vector cleared");

        // line 3: edge tiles and mixed masks
        issue(1, 63, 3, "R5 store by tile 63");
        issue(1, 0, 3, "R5 store takes line from tile 63");
        issue(3, 7, 3, "R7 ifetch downgrades owner");
        issue(1, 7, 3, "R5 store with data and icache holders");

        // line 4: every tile shares, then one store
        for (int t = 0; t < NT; t++) issue(0, t, 4, "R3 R10 wide sharing");
        issue(1, 10, 4, "R10 store collects 63 replies");

        for (int i = 0; i < 400 && (snoop_q.size() + grant_q.size() + ack_q.size() != 0 || !req_ready); i++)
            @(negedge clk);
        check(snoop_q.size() == 0, "R10 snoops outstanding at end", NT'(snoop_q.size()), '0);
        check(grant_q.size() == 0, "R11 grants outstanding at end", NT'(grant_q.size()), '0);
        finish_run();
    end

endmodule